// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Supervisor

This block starts and watches the link of a PCIe root port. A start pulse begins the bring-up. The block holds the endpoint reset low for a fixed time and then releases it. It waits the same time again so the endpoint can settle. Next it reads the link-capability word in configuration space and writes it back with the maximum-speed field forced to Gen1. Only after that does it enable the link training state machine.

From then on the block polls two debug words at a fixed interval. It stops with link_up when the link reports up and is no longer training. On each unsuccessful poll it reads the receiver-valid register of the PHY. If the receiver is not valid while the LTSSM sits in Recovery.RcvrLock, a speed change to Gen2 is stuck. The block then forces two receiver override bits on in a PHY register, holds them for a fixed time, and clears them again.

The PHY is reached through a request/response port for 16-bit registers. After a fixed number of unsuccessful polls the block stops and raises fail. All time intervals scale with a clock-cycles-per-microsecond parameter.

Top module: `pcie_link_sup`

## Requirements
- R1: After reset, ep_rst_n, ltssm_en, link_up, fail and busy are all 0, and no request is raised on either access port.
- R2: A start pulse raises busy and holds ep_rst_n low for at least PERST_US*CYC_PER_US cycles. ep_rst_n then goes high, and the first configuration request waits at least that many cycles more.
- R3: The block reads configuration offset 0x7C and writes back the same word with bits [3:0] replaced by 4'h1. All other bits are kept.
- R4: ltssm_en rises only after the capability write has been acknowledged, and it is never high while ep_rst_n is low.
- R5: The link counts as up only when flag_dbg bit 4 is 1 and flag_dbg bit 29 is 0. On that, link_up goes to 1, busy to 0 and fail stays 0.
- R6: Every poll that finds the link not up reads PHY register 0x100D. Consecutive reads are at least POLL_US*CYC_PER_US cycles apart.
- R7: Recovery starts only when bit 0 of the 0x100D read data is 0 and state_dbg[5:0] equals 6'h0D. Otherwise PHY register 0x1005 is not accessed.
- R8: Recovery reads 0x1005 and writes it back with bits 5 and 3 set. At least HOLD_US*CYC_PER_US cycles later it reads 0x1005 again and writes it back with bits 5 and 3 cleared. All other bits are kept in both writes.
- R9: After MAX_POLLS unsuccessful polls, fail goes to 1 and busy to 0, and no further PHY requests are made.
- R10: A PHY error response during recovery abandons the rest of that recovery, and polling continues with the next read of 0x100D.
- R11: While phy_req is high and neither phy_ack nor phy_err has arrived, the request, its address, write flag and write data stay unchanged.
- R12: A start pulse in any state restarts the whole sequence. In the next cycle link_up and fail are 0, busy is 1, and ep_rst_n and ltssm_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts or restarts bring-up |
| ep_rst_n | output | 1 | Endpoint reset, active low |
| ltssm_en | output | 1 | Enables link training |
| cfg_req | output | 1 | Configuration access request |
| cfg_we | output | 1 | Configuration write (1) or read (0) |
| cfg_addr | output | 12 | Configuration byte offset |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| cfg_ack | input | 1 | Configuration access done |
| phy_req | output | 1 | PHY register access request |
| phy_we | output | 1 | PHY write (1) or read (0) |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack |
| phy_ack | input | 1 | PHY access completed |
| phy_err | input | 1 | PHY access failed |
| flag_dbg | input | 32 | Debug word with link-up and in-training flags |
| state_dbg | input | 32 | Debug word whose low 6 bits give the LTSSM state |
| link_up | output | 1 | Link brought up |
| fail | output | 1 | Poll budget used up |
| busy | output | 1 | Sequence in progress |

## Verification
Two functions can meet in the same cycle: a restart and a recovery already in flight. A PHY error can also land on the very handshake that would have finished the override write. The bench pulses start while the override hold timer is running. At the next sample it judges that busy, the endpoint reset and the training enable have returned to their start-up values, and that the rerun still reaches link-up. The bench also makes its PHY model answer the set-write with an error instead of an acknowledge. It judges that no override write took effect, that no second read of 0x1005 followed, and that the next poll read 0x100D again.

// File: rtl/lss_pkg.sv
package lss_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_RST_SETTLE,
    ST_CAP_RD,
    ST_CAP_WR,
    ST_POLL,
    ST_RXV_RD,
    ST_OVR_RD1,
    ST_OVR_WR1,
    ST_HOLD,
    ST_OVR_RD2,
    ST_OVR_WR2,
    ST_PWAIT,
    ST_UP,
    ST_FAIL
  } lss_state_e;

  localparam logic [11:0] CAP_OFS      = 12'h07C;
  localparam logic [3:0]  GEN1_CODE    = 4'h1;
  localparam logic [15:0] PHY_RXV_ADDR = 16'h100D;
  localparam logic [15:0] PHY_OVR_ADDR = 16'h1005;
  localparam logic [15:0] OVR_MASK     = 16'h0028;
  localparam logic [5:0]  LOCK_CODE    = 6'h0D;
  localparam int unsigned UP_BIT       = 4;
  localparam int unsigned TRAIN_BIT    = 29;

endpackage

// File: rtl/lss_timer.sv
module lss_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  a_r2_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lss_status.sv
module lss_status import lss_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] flag_word,
  input  logic [31:0] state_word,
  output logic        link_ok,
  output logic        in_lock
);

  logic ok_d, lock_d;
  logic unused_bits;

  always_comb begin
    ok_d   = flag_word[UP_BIT] && !flag_word[TRAIN_BIT];
    lock_d = (state_word[5:0] == LOCK_CODE);
  end

  assign unused_bits = ^{flag_word[31:30], flag_word[28:5], flag_word[3:0],
                         state_word[31:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_ok <= 1'b0;
      in_lock <= 1'b0;
    end else begin
      link_ok <= ok_d;
      in_lock <= lock_d;
    end
  end

endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl import lss_pkg::*; #(
  parameter int unsigned TW        = 8,
  parameter int unsigned PCW       = 4,
  parameter int unsigned PERST_CYC = 100,
  parameter int unsigned POLL_CYC  = 10,
  parameter int unsigned HOLD_CYC  = 50,
  parameter int unsigned MAX_POLLS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          link_ok,
  input  logic          in_lock,
  input  logic          tmr_exp,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          cfg_req,
  output logic          cfg_we,
  output logic [11:0]   cfg_addr,
  output logic [31:0]   cfg_wdata,
  input  logic [31:0]   cfg_rdata,
  input  logic          cfg_ack,
  output logic          phy_req,
  output logic          phy_we,
  output logic [15:0]   phy_addr,
  output logic [15:0]   phy_wdata,
  input  logic [15:0]   phy_rdata,
  input  logic          phy_ack,
  input  logic          phy_err,
  output logic          ep_rst_n,
  output logic          ltssm_en,
  output logic          link_up,
  output logic          fail,
  output logic          busy
);

  lss_state_e       st_q, st_d;
  logic [31:4]      cap_q;
  logic             cap_en;
  logic [15:0]      ovr_q, ovr_nx;
  logic             ovr_en;
  logic [PCW-1:0]   polls_q, polls_d;
  logic             go_wait;
  logic             unused_cfg;

  assign unused_cfg = ^cfg_rdata[3:0];

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cap_en    = 1'b0;
    ovr_en    = 1'b0;
    ovr_nx    = ovr_q;
    polls_d   = polls_q;
    go_wait   = 1'b0;
    cfg_req   = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = CAP_OFS;
    cfg_wdata = '0;
    phy_req   = 1'b0;
    phy_we    = 1'b0;
    phy_addr  = '0;
    phy_wdata = '0;
    case (st_q)
      ST_RST_HOLD: if (tmr_exp) begin
        st_d     = ST_RST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = TW'(PERST_CYC);
      end
      ST_RST_SETTLE: if (tmr_exp) st_d = ST_CAP_RD;
      ST_CAP_RD: begin
        cfg_req = 1'b1;
        if (cfg_ack) begin
          cap_en = 1'b1;
          st_d   = ST_CAP_WR;
        end
      end
      ST_CAP_WR: begin
        cfg_req   = 1'b1;
        cfg_we    = 1'b1;
        cfg_wdata = {cap_q, GEN1_CODE};
        if (cfg_ack) st_d = ST_POLL;
      end
      ST_POLL: st_d = link_ok ? ST_UP : ST_RXV_RD;
      ST_RXV_RD: begin
        phy_req  = 1'b1;
        phy_addr = PHY_RXV_ADDR;
        if (phy_ack) begin
          if (!phy_rdata[0] && in_lock) st_d = ST_OVR_RD1;
          else go_wait = 1'b1;
        end else if (phy_err) go_wait = 1'b1;
      end
      ST_OVR_RD1: begin
        phy_req  = 1'b1;
        phy_addr = PHY_OVR_ADDR;
        if (phy_ack) begin
          ovr_en = 1'b1;
          ovr_nx = phy_rdata | OVR_MASK;
          st_d   = ST_OVR_WR1;
        end else if (phy_err) go_wait = 1'b1;
      end
      ST_OVR_WR1: begin
        phy_req   = 1'b1;
        phy_we    = 1'b1;
        phy_addr  = PHY_OVR_ADDR;
        phy_wdata = ovr_q;
        if (phy_ack) begin
          st_d     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = TW'(HOLD_CYC);
        end else if (phy_err) go_wait = 1'b1;
      end
      ST_HOLD: if (tmr_exp) st_d = ST_OVR_RD2;
      ST_OVR_RD2: begin
        phy_req  = 1'b1;
        phy_addr = PHY_OVR_ADDR;
        if (phy_ack) begin
          ovr_en = 1'b1;
          ovr_nx = phy_rdata & ~OVR_MASK;
          st_d   = ST_OVR_WR2;
        end else if (phy_err) go_wait = 1'b1;
      end
      ST_OVR_WR2: begin
        phy_req   = 1'b1;
        phy_we    = 1'b1;
        phy_addr  = PHY_OVR_ADDR;
        phy_wdata = ovr_q;
        if (phy_ack || phy_err) go_wait = 1'b1;
      end
      ST_PWAIT: if (tmr_exp) begin
        polls_d = polls_q + 1'b1;
        st_d    = (polls_q == PCW'(MAX_POLLS - 1)) ? ST_FAIL : ST_POLL;
      end
      default: st_d = st_q;
    endcase
    if (go_wait) begin
      st_d     = ST_PWAIT;
      tmr_load = 1'b1;
      tmr_val  = TW'(POLL_CYC);
    end
    if (start) begin
      st_d     = ST_RST_HOLD;
      tmr_load = 1'b1;
      tmr_val  = TW'(PERST_CYC);
      polls_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      polls_q  <= '0;
      link_up  <= 1'b0;
      fail     <= 1'b0;
      busy     <= 1'b0;
      ep_rst_n <= 1'b0;
      ltssm_en <= 1'b0;
    end else begin
      st_q     <= st_d;
      polls_q  <= polls_d;
      link_up  <= (st_d == ST_UP);
      fail     <= (st_d == ST_FAIL);
      busy     <= !(st_d inside {ST_IDLE, ST_UP, ST_FAIL});
      ep_rst_n <= !(st_d inside {ST_IDLE, ST_RST_HOLD});
      ltssm_en <= !(st_d inside {ST_IDLE, ST_RST_HOLD, ST_RST_SETTLE,
                                 ST_CAP_RD, ST_CAP_WR});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (cap_en) cap_q <= cfg_rdata[31:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= '0;
    else if (ovr_en) ovr_q <= ovr_nx;
  end

  a_r4_ltssm_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_en |-> ep_rst_n);

  a_r4_ltssm_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en) |-> $past(cfg_ack && cfg_we));

  a_r5_up_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(link_ok));

  a_r9_fail_after_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ($past(polls_q) == PCW'(MAX_POLLS - 1)));

endmodule

// File: rtl/pcie_link_sup.sv
module pcie_link_sup import lss_pkg::*; #(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned PERST_US   = 20000,
  parameter int unsigned POLL_US    = 10,
  parameter int unsigned HOLD_US    = 3000,
  parameter int unsigned MAX_POLLS  = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        ep_rst_n,
  output logic        ltssm_en,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [11:0] cfg_addr,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata,
  input  logic        cfg_ack,
  output logic        phy_req,
  output logic        phy_we,
  output logic [15:0] phy_addr,
  output logic [15:0] phy_wdata,
  input  logic [15:0] phy_rdata,
  input  logic        phy_ack,
  input  logic        phy_err,
  input  logic [31:0] flag_dbg,
  input  logic [31:0] state_dbg,
  output logic        link_up,
  output logic        fail,
  output logic        busy
);

  localparam int unsigned PERST_CYC = CYC_PER_US * PERST_US;
  localparam int unsigned POLL_CYC  = CYC_PER_US * POLL_US;
  localparam int unsigned HOLD_CYC  = CYC_PER_US * HOLD_US;
  localparam int unsigned T_A       = (PERST_CYC > HOLD_CYC) ? PERST_CYC : HOLD_CYC;
  localparam int unsigned T_MAX     = (T_A > POLL_CYC) ? T_A : POLL_CYC;
  localparam int unsigned TW        = $clog2(T_MAX + 1);
  localparam int unsigned PCW       = $clog2(MAX_POLLS + 1);

  logic          link_ok, in_lock;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;

  lss_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_word  (flag_dbg),
    .state_word (state_dbg),
    .link_ok    (link_ok),
    .in_lock    (in_lock)
  );

  lss_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  lss_ctrl #(
    .TW        (TW),
    .PCW       (PCW),
    .PERST_CYC (PERST_CYC),
    .POLL_CYC  (POLL_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .MAX_POLLS (MAX_POLLS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .link_ok   (link_ok),
    .in_lock   (in_lock),
    .tmr_exp   (tmr_exp),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_ack   (cfg_ack),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_rdata (phy_rdata),
    .phy_ack   (phy_ack),
    .phy_err   (phy_err),
    .ep_rst_n  (ep_rst_n),
    .ltssm_en  (ltssm_en),
    .link_up   (link_up),
    .fail      (fail),
    .busy      (busy)
  );

  a_r11_phy_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ack && !phy_err && !start) |=>
      (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!phy_req && !cfg_req));

endmodule

// File: tb/pcie_link_sup_tb_top.sv
module pcie_link_sup_tb_top;

  localparam int CLK_NS    = 10;
  localparam int CPU       = 2;
  localparam int PERST_US  = 10;
  localparam int POLL_US   = 5;
  localparam int HOLD_US   = 20;
  localparam int MAXP      = 6;
  localparam int PERST_CYC = CPU * PERST_US;
  localparam int POLL_CYC  = CPU * POLL_US;
  localparam int HOLD_CYC  = CPU * HOLD_US;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ep_rst_n, ltssm_en, cfg_req, cfg_we, phy_req, phy_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;
  logic        cfg_ack = 1'b0;
  logic [15:0] phy_addr, phy_wdata;
  logic [15:0] phy_rdata = '0;
  logic        phy_ack = 1'b0;
  logic        phy_err = 1'b0;
  logic [31:0] flag_dbg = '0;
  logic [31:0] state_dbg = '0;
  logic        link_up, fail, busy;

  logic [31:0] cap_init = 32'hABCD_0032;
  logic [15:0] ovr_seed = 16'h0000;
  logic        rxv_bit = 1'b1;
  logic        err_mode = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int viol = 0;

  logic [31:0] cap_wr_val = '0;
  logic        ltssm_at_wr = 1'b0;
  logic        cfg_wait = 1'b0;
  int          cap_rd_addr = 0;

  logic [15:0] ovr_reg = '0;
  int          p_wait = 0;
  int          n_rxv_rd = 0, n_ovr_rd = 0, n_ovr_wr = 0, n_err = 0;
  int          last_rxv = 0, min_gap = 1000000;
  logic [15:0] w1_val = '0, w2_val = '0;
  int          w1_cyc = 0, w2_cyc = 0;

  pcie_link_sup #(
    .CYC_PER_US (CPU),
    .PERST_US   (PERST_US),
    .POLL_US    (POLL_US),
    .HOLD_US    (HOLD_US),
    .MAX_POLLS  (MAXP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ep_rst_n(ep_rst_n), .ltssm_en(ltssm_en),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_ack(phy_ack),
    .phy_err(phy_err), .flag_dbg(flag_dbg), .state_dbg(state_dbg),
    .link_up(link_up), .fail(fail), .busy(busy)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && ltssm_en && !ep_rst_n) viol <= viol + 1;

  // configuration space model: one wait cycle, then acknowledge
  always @(posedge clk) begin
    cfg_ack <= 1'b0;
    if (cfg_ack) cfg_wait <= 1'b0;
    else if (cfg_req) begin
      if (!cfg_wait) cfg_wait <= 1'b1;
      else begin
        cfg_wait <= 1'b0;
        cfg_ack  <= 1'b1;
        if (cfg_we) begin
          cap_wr_val  <= cfg_wdata;
          ltssm_at_wr <= ltssm_en;
        end else begin
          cfg_rdata   <= cap_init;
          cap_rd_addr <= int'(cfg_addr);
        end
      end
    end else cfg_wait <= 1'b0;
  end

  // PHY register model: two wait cycles, optional error on first override write
  always @(posedge clk) begin
    phy_ack <= 1'b0;
    phy_err <= 1'b0;
    if (start) begin
      p_wait   <= 0;
      ovr_reg  <= ovr_seed;
      n_rxv_rd <= 0; n_ovr_rd <= 0; n_ovr_wr <= 0; n_err <= 0;
      min_gap  <= 1000000;
    end else if (phy_ack || phy_err) p_wait <= 0;
    else if (phy_req) begin
      if (p_wait < 2) p_wait <= p_wait + 1;
      else begin
        p_wait <= 0;
        if (err_mode && n_err == 0 && phy_we && phy_addr == 16'h1005) begin
          phy_err <= 1'b1;
          n_err   <= n_err + 1;
        end else begin
          phy_ack <= 1'b1;
          if (phy_we) begin
            if (phy_addr == 16'h1005) begin
              ovr_reg  <= phy_wdata;
              n_ovr_wr <= n_ovr_wr + 1;
              if (n_ovr_wr == 0) begin w1_val <= phy_wdata; w1_cyc <= cyc; end
              if (n_ovr_wr == 1) begin w2_val <= phy_wdata; w2_cyc <= cyc; end
            end
          end else if (phy_addr == 16'h100D) begin
            phy_rdata <= {15'h0, rxv_bit};
            if (n_rxv_rd > 0 && (cyc - last_rxv) < min_gap) min_gap <= cyc - last_rxv;
            last_rxv <= cyc;
            n_rxv_rd <= n_rxv_rd + 1;
          end else if (phy_addr == 16'h1005) begin
            phy_rdata <= ovr_reg;
            n_ovr_rd  <= n_ovr_rd + 1;
          end else phy_rdata <= 16'h0;
        end
      end
    end else p_wait <= 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_link(input int lim);
    for (int i = 0; i < lim && !link_up; i++) @(negedge clk);
  endtask

  task automatic wait_fail(input int lim);
    for (int i = 0; i < lim && !fail; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ep_rst_n == 0 && ltssm_en == 0, "R1", "reset ep_rst_n/ltssm_en", {ep_rst_n, ltssm_en}, 0);
    chk(link_up == 0 && fail == 0 && busy == 0, "R1", "reset status", {link_up, fail, busy}, 0);
    chk(phy_req == 0 && cfg_req == 0, "R1", "reset requests", {phy_req, cfg_req}, 0);
  endtask

  task automatic t_link_up();
    int low = 0;
    int settle = 0;
    flag_dbg = 32'h0000_0010; state_dbg = 32'h0000_0011; rxv_bit = 1'b1;
    pulse_start();
    chk(busy == 1, "R2", "busy after start", busy, 1);
    while (!ep_rst_n && low < 500) begin low++; @(negedge clk); end
    chk(low >= PERST_CYC && low <= PERST_CYC + 4, "R2", "endpoint reset low cycles", low, PERST_CYC);
    while (!cfg_req && settle < 500) begin settle++; @(negedge clk); end
    chk(settle >= PERST_CYC, "R2", "settle before config", settle, PERST_CYC);
    wait_link(400);
    chk(cap_rd_addr == 32'h7C, "R3", "capability offset", cap_rd_addr, 32'h7C);
    chk(cap_wr_val == 32'hABCD_0031, "R3", "capability write", cap_wr_val, 32'hABCD_0031);
    chk(ltssm_at_wr == 0, "R4", "ltssm_en low at capability write", ltssm_at_wr, 0);
    chk(link_up == 1 && busy == 0 && fail == 0, "R5", "link up status", {link_up, busy, fail}, 3'b100);
    chk(ltssm_en == 1 && ep_rst_n == 1, "R4", "training enabled", {ltssm_en, ep_rst_n}, 2'b11);
    chk(n_rxv_rd == 0, "R5", "no PHY poll when up at once", n_rxv_rd, 0);
  endtask

  // link-up flag with training still set, LTSSM in lock but receiver valid
  task automatic t_training_lock_valid();
    flag_dbg = 32'h2000_0010; state_dbg = 32'h0000_000D; rxv_bit = 1'b1; ovr_seed = 16'h0;
    pulse_start();
    chk(link_up == 0, "R12", "restart clears link_up", link_up, 0);
    wait_fail(3000);
    chk(fail == 1 && busy == 0 && link_up == 0, "R9", "fail status", {fail, busy, link_up}, 3'b100);
    chk(n_rxv_rd == MAXP, "R9", "poll reads before fail", n_rxv_rd, MAXP);
    chk(n_ovr_rd == 0 && n_ovr_wr == 0, "R7", "no override with receiver valid", n_ovr_rd + n_ovr_wr, 0);
    chk(min_gap >= POLL_CYC, "R6", "poll spacing", min_gap, POLL_CYC);
    repeat (60) @(negedge clk);
    chk(n_rxv_rd == MAXP && phy_req == 0, "R9", "no requests after fail", n_rxv_rd, MAXP);
  endtask

  // receiver not valid but LTSSM elsewhere
  task automatic t_no_lock();
    flag_dbg = 32'h0000_0000; state_dbg = 32'h0000_0011; rxv_bit = 1'b0;
    pulse_start();
    chk(fail == 0 && busy == 1 && ep_rst_n == 0, "R12", "restart from fail", {fail, busy, ep_rst_n}, 3'b010);
    wait_fail(3000);
    chk(fail == 1, "R5", "flag bit4 clear never up", fail, 1);
    chk(n_ovr_rd == 0 && n_ovr_wr == 0, "R7", "no override outside lock", n_ovr_rd + n_ovr_wr, 0);
  endtask

  task automatic t_recovery();
    flag_dbg = 32'h0000_0000; state_dbg = 32'hFFFF_FFCD; rxv_bit = 1'b0; ovr_seed = 16'h8124;
    pulse_start();
    for (int i = 0; i < 800 && n_ovr_wr < 2; i++) @(negedge clk);
    flag_dbg = 32'h0000_0010;
    chk(n_ovr_wr == 2, "R8", "two override writes", n_ovr_wr, 2);
    chk(w1_val == 16'h812C, "R8", "override set value", w1_val, 16'h812C);
    chk(w2_val == 16'h8104, "R8", "override clear value", w2_val, 16'h8104);
    chk((w2_cyc - w1_cyc) >= HOLD_CYC, "R8", "override hold cycles", w2_cyc - w1_cyc, HOLD_CYC);
    wait_link(400);
    chk(link_up == 1 && fail == 0, "R5", "link up after recovery", {link_up, fail}, 2'b10);
  endtask

  task automatic t_phy_error();
    flag_dbg = 32'h0000_0000; state_dbg = 32'h0000_000D; rxv_bit = 1'b0; ovr_seed = 16'h0001;
    err_mode = 1'b1;
    pulse_start();
    for (int i = 0; i < 800 && n_rxv_rd < 2; i++) @(negedge clk);
    chk(n_err == 1, "R10", "error injected", n_err, 1);
    chk(n_ovr_wr == 0 && n_ovr_rd == 1, "R10", "recovery abandoned", {n_ovr_wr[15:0], n_ovr_rd[15:0]}, 32'h0000_0001);
    chk(n_rxv_rd == 2, "R10", "polling resumed", n_rxv_rd, 2);
    flag_dbg = 32'h0000_0010;
    wait_link(800);
    chk(link_up == 1, "R10", "link up after error", link_up, 1);
    err_mode = 1'b0;
  endtask

  task automatic t_restart_mid();
    flag_dbg = 32'h0000_0000; state_dbg = 32'h0000_000D; rxv_bit = 1'b0; ovr_seed = 16'h0;
    pulse_start();
    for (int i = 0; i < 800 && n_ovr_wr < 1; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    pulse_start();
    chk(busy == 1 && link_up == 0 && fail == 0, "R12", "restart status", {busy, link_up, fail}, 3'b100);
    chk(ep_rst_n == 0 && ltssm_en == 0, "R12", "restart reset outputs", {ep_rst_n, ltssm_en}, 0);
    flag_dbg = 32'h0000_0010;
    wait_link(800);
    chk(link_up == 1, "R12", "rerun reaches link up", link_up, 1);
  endtask

  initial begin
    #(CLK_NS * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_link_up();
    t_training_lock_valid();
    t_no_lock();
    t_recovery();
    t_phy_error();
    t_restart_mid();
    chk(viol == 0, "R4", "ltssm_en high while endpoint in reset", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule